// File: doc/BRIEF.md
# Coil Driver Enable and Fault Latch Controller

This block decides when the coil output buffers of a gauge driver may drive their load. It combines an external enable pin, one overcurrent flag for each coil, a single overtemperature flag and a one-cycle strobe that marks the commit edge of the serial port. The commit edge is the moment the chip select line falls. The block also produces a status line for an open-drain pin that is pulled low whenever the buffers are off. The analog fault sensing sits elsewhere, and the flags arrive here as asynchronous digital levels.

The buffers turn on only at a commit strobe, and only when the enable pin is high at that moment. Once on, they drop out when the enable pin goes low or when any synchronized fault flag is seen. After either event they stay off until a later commit strobe, even if the cause has gone away. A fault that is present at the commit strobe wins, so a driver that still sees a fault does not turn on at all. A sticky cause register records the synchronized fault vector of the most recent trip, so software can read why the driver went off.

Top module: `gauge_drive_guard`

## Requirements
- R1: After reset `drvEnable` is 0, `statusLow` is 1 and `faultCause` is 0. The buffers remain off with `enPin` high until a commit strobe arrives.
- R2: A commit strobe sampled with `enPin` high and no synchronized fault sets `drvEnable` to 1 at that same clock edge.
- R3: A commit strobe sampled with `enPin` low leaves `drvEnable` at 0.
- R4: While on, a low `enPin` sampled at an edge clears `drvEnable` at that edge. A later return of `enPin` to high does not set it again without a new commit strobe.
- R5: Each fault flag passes through a two-flop synchronizer. Any coil overcurrent bit or the overtemperature flag, held high from before edge k, clears `drvEnable` at edge k+2 counted from the first sampling edge (three edges in total).
- R6: After a fault trip, `drvEnable` stays 0 after the flags clear, until a commit strobe.
- R7: A commit strobe in a cycle where a synchronized fault is present leaves `drvEnable` at 0. A later commit after the fault has cleared turns it on.
- R8: `statusLow` is always the inverse of `drvEnable`.
- R9: A trip is a synchronized fault seen while on, or at a commit strobe with `enPin` high. On a trip, `faultCause` loads the synchronized vector: bit i (i < NUM_COILS) is the overcurrent flag of coil i and bit NUM_COILS is overtemperature. It holds that value until the next trip and a commit does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low power-on reset |
| enPin | input | 1 | External output enable level, assumed synchronous |
| commitStrobe | input | 1 | One-cycle pulse at the chip select falling edge |
| ocFlag | input | NUM_COILS | Asynchronous overcurrent flags, one for each coil |
| otFlag | input | 1 | Asynchronous overtemperature flag |
| drvEnable | output | 1 | Enable for all coil output buffers |
| statusLow | output | 1 | Pull-down request for the open-drain status pin |
| faultCause | output | NUM_COILS+1 | Synchronized fault vector captured at the last trip |

## Verification
A wrong armed state shows at once on `drvEnable` and `statusLow`, at the edge after the stimulus that should have set or cleared it. Examples are a driver that turns on without a commit, turns on again when enable returns, or stays on through a fault. A wrong synchronizer depth shifts the fault drop-out by one edge in either direction, and the bench times that edge exactly. A bad capture in the cause register stays visible on `faultCause` until the next trip. The bench therefore checks it both at the trip and after later commits that must leave it unchanged.

// File: rtl/gauge_drive_guard_pkg.sv
package gauge_drive_guard_pkg;

  typedef enum logic {
    DRV_OFF = 1'b0,
    DRV_ON  = 1'b1
  } drvState_e;

  // Strobes passed from the arming control to the fault datapath.
  typedef struct packed {
    logic captureCause;  // load sticky cause register this edge
    logic driveOn;       // buffers currently enabled
  } guardStrobes_t;

endpackage

// File: rtl/gauge_sync_chain.sv
module gauge_sync_chain #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/gauge_fault_path.sv
module gauge_fault_path
  import gauge_drive_guard_pkg::*;
#(
  parameter int NUM_COILS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_COILS-1:0] ocFlag,
  input  logic                 otFlag,
  input  guardStrobes_t        strobes,
  output logic                 faultAny,
  output logic [NUM_COILS:0]   faultCause,
  output logic                 drvEnable,
  output logic                 statusLow
);

  localparam int FLT_W = NUM_COILS + 1;

  logic [FLT_W-1:0] rawFault;
  logic [FLT_W-1:0] syncFault;
  logic [FLT_W-1:0] causeQ;

  assign rawFault = {otFlag, ocFlag};

  gauge_sync_chain #(
    .WIDTH (FLT_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawFault),
    .dout(syncFault)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     causeQ <= '0;
    else if (strobes.captureCause) causeQ <= syncFault;
  end

  assign faultAny   = |syncFault;
  assign faultCause = causeQ;
  assign drvEnable  = strobes.driveOn;
  assign statusLow  = ~strobes.driveOn;

endmodule

// File: rtl/gauge_arm_ctrl.sv
module gauge_arm_ctrl
  import gauge_drive_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          enPin,
  input  logic          commitStrobe,
  input  logic          faultAny,
  output guardStrobes_t strobes
);

  drvState_e stateQ, stateD;
  logic      armAttempt;

  assign armAttempt = commitStrobe && enPin;

  always_comb begin
    stateD = stateQ;
    if (faultAny)          stateD = DRV_OFF;   // fault wins over commit
    else if (commitStrobe) stateD = enPin ? DRV_ON : DRV_OFF;
    else if (!enPin)       stateD = DRV_OFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= DRV_OFF;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobes.driveOn      = (stateQ == DRV_ON);
    strobes.captureCause = faultAny && ((stateQ == DRV_ON) || armAttempt);
  end

endmodule

// File: rtl/gauge_drive_guard.sv
module gauge_drive_guard
  import gauge_drive_guard_pkg::*;
#(
  parameter int NUM_COILS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enPin,
  input  logic                 commitStrobe,
  input  logic [NUM_COILS-1:0] ocFlag,
  input  logic                 otFlag,
  output logic                 drvEnable,
  output logic                 statusLow,
  output logic [NUM_COILS:0]   faultCause
);

  guardStrobes_t strobes;
  logic          faultAnySync;

  gauge_arm_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enPin       (enPin),
    .commitStrobe(commitStrobe),
    .faultAny    (faultAnySync),
    .strobes     (strobes)
  );

  gauge_fault_path #(
    .NUM_COILS  (NUM_COILS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ocFlag    (ocFlag),
    .otFlag    (otFlag),
    .strobes   (strobes),
    .faultAny  (faultAnySync),
    .faultCause(faultCause),
    .drvEnable (drvEnable),
    .statusLow (statusLow)
  );

endmodule

// File: rtl/gauge_drive_guard_chk.sv
module gauge_drive_guard_chk #(
  parameter int NUM_COILS = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               enPin,
  input logic               commitStrobe,
  input logic               faultAnySync,
  input logic               drvEnable,
  input logic [NUM_COILS:0] faultCause
);

  a_r1_reset_off: assert property (@(posedge clk) !rstN |=> !drvEnable);

  a_r4_enable_low_drops: assert property (@(posedge clk) disable iff (!rstN)
    !enPin |=> !drvEnable);

  a_r2_rise_needs_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drvEnable) |-> ($past(commitStrobe) && $past(enPin)));

  a_r7_fault_blocks: assert property (@(posedge clk) disable iff (!rstN)
    faultAnySync |=> !drvEnable);

  a_r6_stays_off: assert property (@(posedge clk) disable iff (!rstN)
    (!drvEnable && !commitStrobe) |=> !drvEnable);

  a_r9_cause_holds: assert property (@(posedge clk) disable iff (!rstN)
    !faultAnySync |=> $stable(faultCause));

endmodule

bind gauge_drive_guard gauge_drive_guard_chk #(.NUM_COILS(NUM_COILS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enPin       (enPin),
  .commitStrobe(commitStrobe),
  .faultAnySync(faultAnySync),
  .drvEnable   (drvEnable),
  .faultCause  (faultCause)
);

// File: tb/gauge_drive_guard_bench.sv
module gauge_drive_guard_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enPin = 1'b0;
  logic       commitStrobe = 1'b0;
  logic [1:0] ocFlag = 2'b00;
  logic       otFlag = 1'b0;
  logic       drvEnable;
  logic       statusLow;
  logic [2:0] faultCause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Requirement model: two-flop sync and armed flag.
  logic [2:0] m1 = '0, m2 = '0, mCause = '0;
  logic       mOn = 1'b0;

  always #2 clk = ~clk;

  gauge_drive_guard u_gauge_drive_guard (
    .clk         (clk),
    .rstN        (rstN),
    .enPin       (enPin),
    .commitStrobe(commitStrobe),
    .ocFlag      (ocFlag),
    .otFlag      (otFlag),
    .drvEnable   (drvEnable),
    .statusLow   (statusLow),
    .faultCause  (faultCause)
  );

  function automatic logic nextOn(input logic on, input logic anyF,
                                  input logic cm, input logic en);
    if (anyF)    return 1'b0;
    else if (cm) return en;
    else if (!en) return 1'b0;
    return on;
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic cm, input logic [2:0] flt);
    logic anyF;
    enPin = en; commitStrobe = cm; ocFlag = flt[1:0]; otFlag = flt[2];
    @(posedge clk);
    anyF = |m2;
    if (anyF && (mOn || (cm && en))) mCause = m2;
    mOn = nextOn(mOn, anyF, cm, en);
    m2 = m1;
    m1 = flt;
    @(negedge clk);
  endtask

  task automatic checkModel();
    check("R5 drvEnable vs model", {2'b00, drvEnable}, {2'b00, mOn});
    check("R8 statusLow", {2'b00, statusLow}, {2'b00, ~mOn});
    check("R9 faultCause vs model", faultCause, mCause);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4192));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 drvEnable in reset", {2'b00, drvEnable}, 3'd0);
    check("R1 statusLow in reset", {2'b00, statusLow}, 3'd1);
    check("R1 faultCause in reset", faultCause, 3'd0);
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 3'b000);
    check("R1 off without commit", {2'b00, drvEnable}, 3'd0);

    // R2: commit with enable high
    step(1'b1, 1'b1, 3'b000);
    check("R2 commit arms", {2'b00, drvEnable}, 3'd1);
    check("R8 status released", {2'b00, statusLow}, 3'd0);

    // R4: enable low drops, return does not rearm
    step(1'b0, 1'b0, 3'b000);
    check("R4 enable low drops", {2'b00, drvEnable}, 3'd0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'b000);
    check("R4 no rearm on enable return", {2'b00, drvEnable}, 3'd0);

    // R3: commit with enable low
    step(1'b0, 1'b1, 3'b000);
    check("R3 commit with enable low", {2'b00, drvEnable}, 3'd0);
    step(1'b1, 1'b1, 3'b000);
    check("R2 rearm", {2'b00, drvEnable}, 3'd1);

    // R5: coil 0 overcurrent, three-edge latency
    step(1'b1, 1'b0, 3'b001);
    check("R5 on after edge 1", {2'b00, drvEnable}, 3'd1);
    step(1'b1, 1'b0, 3'b001);
    check("R5 on after edge 2", {2'b00, drvEnable}, 3'd1);
    step(1'b1, 1'b0, 3'b001);
    check("R5 off after edge 3", {2'b00, drvEnable}, 3'd0);
    check("R9 cause coil0", faultCause, 3'b001);

    // R6: latched off after fault clears
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 3'b000);
    check("R6 latched off", {2'b00, drvEnable}, 3'd0);

    // R7: commit during overtemperature
    step(1'b1, 1'b0, 3'b100);
    step(1'b1, 1'b0, 3'b100);
    step(1'b1, 1'b1, 3'b100);
    check("R7 fault beats commit", {2'b00, drvEnable}, 3'd0);
    check("R9 cause overtemp", faultCause, 3'b100);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'b000);
    step(1'b1, 1'b1, 3'b000);
    check("R7 rearm after clear", {2'b00, drvEnable}, 3'd1);
    step(1'b1, 1'b1, 3'b000);
    check("R9 cause kept over commit", faultCause, 3'b100);

    // Coil 1 overcurrent trip
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'b010);
    check("R5 coil1 trips", {2'b00, drvEnable}, 3'd0);
    check("R9 cause coil1", faultCause, 3'b010);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'b000);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] flt;
      flt = (($urandom % 12) == 0) ? 3'($urandom % 8) : 3'b000;
      step((($urandom % 8) != 0), (($urandom % 4) == 0), flt);
      checkModel();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule